// File: doc/BRIEF.md
# Sequential Radix-2 Booth Multiplier

This block multiplies two signed two's complement operands of `N` bits, default 8, over several clock cycles. A one-cycle `start` pulse, given while the block is idle, captures the multiplicand and the multiplier. The block then performs one Booth step on each clock. A step takes the lowest bit of the multiplier register together with a saved bit that sits just below it. From that pair it chooses to add the multiplicand to a running accumulator, to subtract the multiplicand, or to leave the accumulator unchanged. It then shifts the joined accumulator, multiplier register and saved bit one place to the right, copying the sign bit into the top.

After `N` steps the block writes the `2N`-bit signed product to its output register and raises `done` for a single cycle. It picks its action from each pair of neighbouring multiplier bits, not from each single bit, so a run of ones in the multiplier costs one subtraction and one addition. The accumulator is one bit wider than the operands, so subtracting the most negative multiplicand cannot overflow.

Top module: `boothMul`

## Requirements
- R1: For every pair of `N`-bit signed operands, `product` equals multiplicand times multiplier as a `2N`-bit two's complement number.
- R2: A `start` pulse while `busy` is low captures both operands, and `busy` is high in the cycle after the clock edge that sampled `start`.
- R3: `done` rises exactly `N` clock edges after the edge that sampled the accepted `start`, one Booth step per edge.
- R4: `done` is high for exactly one cycle, and `busy` is low whenever `done` is high.
- R5: A `start` pulse while `busy` is high is ignored: the running operation keeps its timing and its result, whatever operand values come with the pulse.
- R6: `product` changes only on the edge that raises `done`, and keeps its value while a later operation runs.
- R7: When both operands are the most negative value, the product is +2^(2N-2), with no overflow.
- R8: With `N` = 4, multiplier 1100 (-4) times multiplicand 0010 (2) gives `product` 11111000 (-8).
- R9: After reset, `busy` and `done` are low and `product` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a multiplication when idle |
| multiplicand | input | N | Signed multiplicand, captured on accepted start |
| multiplier | input | N | Signed multiplier, captured on accepted start |
| busy | output | 1 | High while Booth steps are in progress |
| done | output | 1 | One-cycle pulse when a new product is ready |
| product | output | 2N | Signed product register |

## Verification
A wrong add, subtract or skip choice, or a shift that fills the top with the wrong bit, corrupts the accumulator at that step. The corruption shows at the ports only when `done` rises `N` edges after `start`, as a wrong `product` for some operand pairs. An exhaustive sweep at `N` = 4 therefore catches each such fault within one operation. A fault in the step counter shows up as `done` rising on the wrong edge. A fault in the busy handling shows up as a changed result or changed timing when `start` is pulsed during a run.

// File: rtl/boothMulPkg.sv
package boothMulPkg;
  // Strobes driven by the control FSM into the datapath
  typedef struct packed {
    logic load;   // capture operands, clear accumulator and saved bit
    logic step;   // perform one add/subtract/skip and arithmetic shift
    logic last;   // this step is the final one; write product register
  } boothStrobeT;

  // Action chosen from {multiplier LSB, saved bit}
  typedef enum logic [1:0] {
    ACT_SKIP = 2'b00,
    ACT_ADD  = 2'b01,
    ACT_SUB  = 2'b10
  } boothActT;
endpackage

// File: rtl/boothMulCtrl.sv
module boothMulCtrl
  import boothMulPkg::*;
#(
  parameter int N = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  output boothStrobeT strobe,
  output logic        busy,
  output logic        done
);
  localparam int CW = $clog2(N + 1);
  localparam logic [CW-1:0] LAST_IDX = CW'(N - 1);

  typedef enum logic {ST_IDLE, ST_RUN} stateT;

  stateT         state;
  logic [CW-1:0] stepCnt;

  always_comb begin
    strobe.load = (state == ST_IDLE) && start;
    strobe.step = (state == ST_RUN);
    strobe.last = (state == ST_RUN) && (stepCnt == LAST_IDX);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
      done    <= 1'b0;
    end else begin
      done <= strobe.last;
      if (strobe.load) begin
        state   <= ST_RUN;
        stepCnt <= '0;
      end else if (strobe.step) begin
        stepCnt <= stepCnt + 1'b1;
        if (strobe.last) state <= ST_IDLE;
      end
    end
  end

  assign busy = (state == ST_RUN);
endmodule

// File: rtl/boothMulDatapath.sv
module boothMulDatapath
  import boothMulPkg::*;
#(
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rstN,
  input  boothStrobeT    strobe,
  input  logic [N-1:0]   multiplicand,
  input  logic [N-1:0]   multiplier,
  output logic [2*N-1:0] product
);
  localparam int AW = N + 1;  // accumulator width, one guard bit

  logic [AW-1:0]  accReg;
  logic [N-1:0]   mqReg;
  logic           savedBit;
  logic [AW-1:0]  mcandReg;

  boothActT       action;
  logic [AW-1:0]  addend;
  logic [AW-1:0]  sum;
  logic [AW-1:0]  nextAcc;
  logic [N-1:0]   nextMq;

  always_comb begin
    action = boothActT'({mqReg[0], savedBit});
    unique case (action)
      ACT_ADD: addend = mcandReg;
      ACT_SUB: addend = ~mcandReg + 1'b1;
      default: addend = '0;
    endcase
    sum     = accReg + addend;
    nextAcc = {sum[AW-1], sum[AW-1:1]};
    nextMq  = {sum[0], mqReg[N-1:1]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accReg   <= '0;
      mqReg    <= '0;
      savedBit <= 1'b0;
      mcandReg <= '0;
      product  <= '0;
    end else begin
      if (strobe.load) begin
        accReg   <= '0;
        mqReg    <= multiplier;
        savedBit <= 1'b0;
        mcandReg <= {multiplicand[N-1], multiplicand};
      end else if (strobe.step) begin
        accReg   <= nextAcc;
        mqReg    <= nextMq;
        savedBit <= mqReg[0];
        if (strobe.last) product <= {nextAcc[N-1:0], nextMq};
      end
    end
  end
endmodule

// File: rtl/boothMul.sv
module boothMul
  import boothMulPkg::*;
#(
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           start,
  input  logic [N-1:0]   multiplicand,
  input  logic [N-1:0]   multiplier,
  output logic           busy,
  output logic           done,
  output logic [2*N-1:0] product
);
  boothStrobeT strobe;

  boothMulCtrl #(.N(N)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .strobe (strobe),
    .busy   (busy),
    .done   (done)
  );

  boothMulDatapath #(.N(N)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .multiplicand (multiplicand),
    .multiplier   (multiplier),
    .product      (product)
  );
endmodule

// File: rtl/boothMulChk.sv
module boothMulChk #(
  parameter int N = 8
) (
  input logic           clk,
  input logic           rstN,
  input logic           start,
  input logic           busy,
  input logic           done,
  input logic [2*N-1:0] product
);
  localparam int CW = $clog2(N + 2);

  logic [CW-1:0] runCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) runCnt <= '0;
    else if (start && !busy) runCnt <= '0;
    else if (busy) runCnt <= runCnt + 1'b1;
  end

  // R3
  done_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (runCnt == CW'(N)));

  // R4
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R4
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R2
  busy_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

  // R5
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done && start && runCnt < CW'(N - 1)) |=> busy);

  // R6
  product_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(product));
endmodule

bind boothMul boothMulChk #(.N(N)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .start   (start),
  .busy    (busy),
  .done    (done),
  .product (product)
);

// File: tb/boothMul_tb.sv
module boothMul_tb;
  localparam int N = 4;
  localparam int CLK_PERIOD = 10;
  localparam int WAIT_LIMIT = 40;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           start = 1'b0;
  logic [N-1:0]   multiplicand = '0;
  logic [N-1:0]   multiplier = '0;
  logic           busy;
  logic           done;
  logic [2*N-1:0] product;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  boothMul #(.N(N)) u_dut (
    .clk          (clk),
    .rstN         (rstN),
    .start        (start),
    .multiplicand (multiplicand),
    .multiplier   (multiplier),
    .busy         (busy),
    .done         (done),
    .product      (product)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Run one multiplication; optionally pulse start with other operands mid-run
  task automatic runOp(input logic [N-1:0] mcand, input logic [N-1:0] mplier, input bit inject);
    int expProd;
    int edges;
    logic [2*N-1:0] heldProd;
    expProd = int'($signed(mcand)) * int'($signed(mplier));
    @(negedge clk);
    multiplicand = mcand;
    multiplier   = mplier;
    start        = 1'b1;
    heldProd     = product;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    multiplicand = ~mcand;
    multiplier   = mplier + 1'b1;
    // R2: busy after accepted start
    check(busy === 1'b1, "R2", longint'(busy), 1);
    edges = 0;
    while (edges < WAIT_LIMIT) begin
      if (inject && edges == 1) start = 1'b1;
      if (inject && edges == 2) start = 1'b0;
      @(posedge clk);
      edges++;
      @(negedge clk);
      if (done === 1'b1) break;
      // R6: product holds while the run is in progress
      if (product !== heldProd) check(1'b0, "R6", longint'(product), longint'(heldProd));
    end
    start = 1'b0;
    // R3: latency of N edges
    check(edges == N, inject ? "R5 R3" : "R3", edges, N);
    // R1 / R5: product value
    check(product === (2*N)'(expProd), inject ? "R5" : "R1",
          longint'($signed(product)), expProd);
    // R4: busy low with done
    check(busy === 1'b0, "R4", longint'(busy), 0);
    @(negedge clk);
    // R4: done lasts one cycle; R6: product still held
    check(done === 1'b0, "R4", longint'(done), 0);
    check(product === (2*N)'(expProd), "R6", longint'($signed(product)), expProd);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    check(busy === 1'b0, "R9", longint'(busy), 0);
    check(done === 1'b0, "R9", longint'(done), 0);
    check(product === '0, "R9", longint'(product), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R8: -4 multiplier times 2 multiplicand
    runOp(4'b0010, 4'b1100, 1'b0);
    check(product === 8'b1111_1000, "R8", longint'(product), 248);

    // R7: both most negative
    runOp(4'b1000, 4'b1000, 1'b0);
    check(product === 8'b0100_0000, "R7", longint'(product), 64);

    // R5: start pulses during runs are ignored
    runOp(4'b0111, 4'b1001, 1'b1);
    runOp(4'b1000, 4'b0111, 1'b1);
    runOp(4'b0000, 4'b1111, 1'b1);

    // R1: exhaustive sweep
    for (int a = 0; a < (1 << N); a++) begin
      for (int b = 0; b < (1 << N); b++) begin
        runOp(N'(a), N'(b), 1'b0);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule